// File: doc/BRIEF.md
# Machine-Mode Source Selector

This block chooses, for each of seven timing outputs, which source select code is in force at any moment. The outputs are three single bunch clocks (BC1, BC2, BCref), a main bunch clock, two orbits and a main orbit. Each output has three stored select codes: one for manual operation, one for use while beam is present and one for use while beam is absent. A working-mode bit for each output picks manual or automatic operation. In automatic operation, the machine-mode number from the timing receiver is classified as beam or no beam through a 32-bit programmable mask, and that class picks the beam or no-beam code.

A two-state classifier machine holds the beam decision. Its states are `CLS_NO_BEAM` and `CLS_BEAM`. The transition `ENTER_BEAM` goes from `CLS_NO_BEAM` to `CLS_BEAM` when the current mode qualifies as beam. The transition `LEAVE_BEAM` goes back when it no longer qualifies. A mode qualifies only when the receiver is ready, the mode number is below the mask width, and the mask bit at that index is 1. The effective select codes and the beam indicator are registered together, so both follow an input change one clock later. The clock and orbit multiplexers that consume these codes sit outside this block.

Top module: `mode_src_selector`

## Requirements
- R1: While reset is asserted, every effective select output and `beam_active` read 0.
- R2: One clock after the inputs are sampled, `beam_active` is 1 exactly when `rx_ready` is 1, `mode_num` is below 32 and `beam_mask[mode_num]` is 1 (mode numbers: 0 no beam, 1 filling, 2 ramping, 3 physics).
- R3: While `rx_ready` is 0, the mode is classed as no beam whatever the mask holds.
- R4: A `mode_num` of 32 or above is classed as no beam, even with an all-ones mask.
- R5: An output whose working-mode bit is 0 (manual) takes its manual select code, whatever the beam class is.
- R6: An output whose working-mode bit is 1 (automatic) takes its beam select code when the mode is classed as beam, and its no-beam code otherwise.
- R7: Working-mode bit positions: bit 0 BC1, bit 1 BC2, bit 2 BCref, bit 3 main bunch clock, bit 4 orbit 1, bit 5 orbit 2, bit 6 main orbit. Each bit affects only its own output.
- R8: The main orbit code is 0 for orbit 1, 1 for orbit 2 and 2 for the internal orbit. A selected code of 3 is output as 2.
- R9: Effective select outputs are registered. A change on any input shows on the outputs one clock later, and not within the same cycle.
- R10: The main bunch-clock code passes unchanged in all four values: 0 internal clock, 1 BCref, 2 BC2, 3 BC1. Single bunch-clock codes are 0 for internal and 1 for external. Single orbit codes are 0 for the orbit input and 1 for the internal orbit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_ready | input | 1 | Timing receiver ready |
| mode_num | input | 8 | Decoded machine-mode number |
| beam_mask | input | 32 | Per-mode beam classification, 1 = beam |
| working_mode | input | 7 | Per-output automatic enable, 1 = automatic |
| bc_man_sel | input | 3 | Manual codes for BC1, BC2, BCref (bit 0 = BC1) |
| bc_beam_sel | input | 3 | Beam codes for BC1, BC2, BCref |
| bc_nobeam_sel | input | 3 | No-beam codes for BC1, BC2, BCref |
| bcm_man_sel | input | 2 | Manual code for main bunch clock |
| bcm_beam_sel | input | 2 | Beam code for main bunch clock |
| bcm_nobeam_sel | input | 2 | No-beam code for main bunch clock |
| orb_man_sel | input | 2 | Manual codes for orbit 1, orbit 2 (bit 0 = orbit 1) |
| orb_beam_sel | input | 2 | Beam codes for orbit 1, orbit 2 |
| orb_nobeam_sel | input | 2 | No-beam codes for orbit 1, orbit 2 |
| orbm_man_sel | input | 2 | Manual code for main orbit |
| orbm_beam_sel | input | 2 | Beam code for main orbit |
| orbm_nobeam_sel | input | 2 | No-beam code for main orbit |
| bc_sel | output | 3 | Effective codes for BC1, BC2, BCref |
| bcm_sel | output | 2 | Effective main bunch-clock code |
| orb_sel | output | 2 | Effective codes for orbit 1, orbit 2 |
| orbm_sel | output | 2 | Effective main orbit code |
| beam_active | output | 1 | Current mode classified as beam |

## Verification
The checker tests several rules on every cycle. It confirms that a not-ready receiver or an out-of-range mode never yields beam, and that an in-range ready mode follows its mask bit one clock later. It confirms that manual outputs copy their manual code, that automatic outputs copy the bank matching the beam class, and that the main orbit never shows code 3. Only the bench scenarios show the reset values and the per-bit independence of the working-mode register across all seven positions. They also show that outputs hold their old value inside the cycle an input changes. Mask walks across every mode index, including the boundary at 31 and 32, likewise need the scenarios.

// File: rtl/msel_pkg.sv
package msel_pkg;

    typedef enum logic {
        CLS_NO_BEAM = 1'b0,
        CLS_BEAM    = 1'b1
    } beam_state_e;

    typedef enum logic [1:0] {
        BANK_MANUAL = 2'd0,
        BANK_BEAM   = 2'd1,
        BANK_NOBEAM = 2'd2
    } bank_e;

    localparam logic [1:0] MORB_INTERNAL = 2'd2;

endpackage

// File: rtl/msel_beam_fsm.sv
module msel_beam_fsm
    import msel_pkg::*;
#(
    parameter int MODE_W = 8,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ready,
    input  logic [MODE_W-1:0] mode_num,
    input  logic [MASK_W-1:0] beam_mask,
    output beam_state_e       state_q,
    output beam_state_e       state_d
);

    localparam int IDX_W = (MASK_W > 1) ? $clog2(MASK_W) : 1;
    localparam logic [MODE_W-1:0] MODE_LIMIT = MODE_W'(MASK_W);

    logic             in_range;
    logic [IDX_W-1:0] mask_idx;
    logic             qualifies;

    assign in_range  = (mode_num < MODE_LIMIT);
    assign mask_idx  = mode_num[IDX_W-1:0];
    assign qualifies = rx_ready && in_range && beam_mask[mask_idx];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CLS_NO_BEAM;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state: ENTER_BEAM / LEAVE_BEAM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLS_NO_BEAM: if (qualifies)  state_d = CLS_BEAM;
            CLS_BEAM:    if (!qualifies) state_d = CLS_NO_BEAM;
            default:     state_d = CLS_NO_BEAM;
        endcase
    end

endmodule

// File: rtl/msel_bank_pick.sv
module msel_bank_pick
    import msel_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         auto_en,
    input  logic         beam,
    input  logic [W-1:0] man_code,
    input  logic [W-1:0] beam_code,
    input  logic [W-1:0] nobeam_code,
    output logic [W-1:0] code
);

    bank_e bank;

    always_comb begin
        if (!auto_en) begin
            bank = BANK_MANUAL;
        end else if (beam) begin
            bank = BANK_BEAM;
        end else begin
            bank = BANK_NOBEAM;
        end
    end

    always_comb begin
        unique case (bank)
            BANK_MANUAL: code = man_code;
            BANK_BEAM:   code = beam_code;
            BANK_NOBEAM: code = nobeam_code;
            default:     code = man_code;
        endcase
    end

endmodule

// File: rtl/msel_code_fold.sv
module msel_code_fold #(
    parameter int W        = 2,
    parameter int MAX_CODE = 2
) (
    input  logic [W-1:0] code_in,
    output logic [W-1:0] code_out
);

    localparam logic [W-1:0] CEIL = W'(MAX_CODE);

    always_comb begin
        if (code_in > CEIL) begin
            code_out = CEIL;
        end else begin
            code_out = code_in;
        end
    end

endmodule

// File: rtl/mode_src_selector.sv
module mode_src_selector
    import msel_pkg::*;
#(
    parameter int MODE_W  = 8,
    parameter int MASK_W  = 32,
    parameter int NUM_BC  = 3,
    parameter int NUM_ORB = 2,
    parameter int MBC_W   = 2,
    parameter int MORB_W  = 2,
    localparam int WM_W   = NUM_BC + NUM_ORB + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_ready,
    input  logic [MODE_W-1:0]  mode_num,
    input  logic [MASK_W-1:0]  beam_mask,
    input  logic [WM_W-1:0]    working_mode,
    input  logic [NUM_BC-1:0]  bc_man_sel,
    input  logic [NUM_BC-1:0]  bc_beam_sel,
    input  logic [NUM_BC-1:0]  bc_nobeam_sel,
    input  logic [MBC_W-1:0]   bcm_man_sel,
    input  logic [MBC_W-1:0]   bcm_beam_sel,
    input  logic [MBC_W-1:0]   bcm_nobeam_sel,
    input  logic [NUM_ORB-1:0] orb_man_sel,
    input  logic [NUM_ORB-1:0] orb_beam_sel,
    input  logic [NUM_ORB-1:0] orb_nobeam_sel,
    input  logic [MORB_W-1:0]  orbm_man_sel,
    input  logic [MORB_W-1:0]  orbm_beam_sel,
    input  logic [MORB_W-1:0]  orbm_nobeam_sel,
    output logic [NUM_BC-1:0]  bc_sel,
    output logic [MBC_W-1:0]   bcm_sel,
    output logic [NUM_ORB-1:0] orb_sel,
    output logic [MORB_W-1:0]  orbm_sel,
    output logic               beam_active
);

    // working-mode bit positions
    localparam int WM_BCM  = NUM_BC;
    localparam int WM_ORB0 = NUM_BC + 1;
    localparam int WM_ORBM = NUM_BC + NUM_ORB + 1;

    beam_state_e cls_q;
    beam_state_e cls_d;
    logic        beam_next;

    logic [NUM_BC-1:0]  bc_d;
    logic [MBC_W-1:0]   bcm_d;
    logic [NUM_ORB-1:0] orb_d;
    logic [MORB_W-1:0]  orbm_raw;
    logic [MORB_W-1:0]  orbm_d;

    msel_beam_fsm #(
        .MODE_W (MODE_W),
        .MASK_W (MASK_W)
    ) i_cls (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ready  (rx_ready),
        .mode_num  (mode_num),
        .beam_mask (beam_mask),
        .state_q   (cls_q),
        .state_d   (cls_d)
    );

    assign beam_next = (cls_d == CLS_BEAM);

    for (genvar gi = 0; gi < NUM_BC; gi++) begin : g_bc
        msel_bank_pick #(.W(1)) i_pick (
            .auto_en     (working_mode[gi]),
            .beam        (beam_next),
            .man_code    (bc_man_sel[gi]),
            .beam_code   (bc_beam_sel[gi]),
            .nobeam_code (bc_nobeam_sel[gi]),
            .code        (bc_d[gi])
        );
    end

    msel_bank_pick #(.W(MBC_W)) i_pick_bcm (
        .auto_en     (working_mode[WM_BCM]),
        .beam        (beam_next),
        .man_code    (bcm_man_sel),
        .beam_code   (bcm_beam_sel),
        .nobeam_code (bcm_nobeam_sel),
        .code        (bcm_d)
    );

    for (genvar gj = 0; gj < NUM_ORB; gj++) begin : g_orb
        msel_bank_pick #(.W(1)) i_pick (
            .auto_en     (working_mode[WM_ORB0 + gj]),
            .beam        (beam_next),
            .man_code    (orb_man_sel[gj]),
            .beam_code   (orb_beam_sel[gj]),
            .nobeam_code (orb_nobeam_sel[gj]),
            .code        (orb_d[gj])
        );
    end

    msel_bank_pick #(.W(MORB_W)) i_pick_orbm (
        .auto_en     (working_mode[WM_ORBM]),
        .beam        (beam_next),
        .man_code    (orbm_man_sel),
        .beam_code   (orbm_beam_sel),
        .nobeam_code (orbm_nobeam_sel),
        .code        (orbm_raw)
    );

    msel_code_fold #(
        .W        (MORB_W),
        .MAX_CODE (int'(MORB_INTERNAL))
    ) i_fold_orbm (
        .code_in  (orbm_raw),
        .code_out (orbm_d)
    );

    // output register: same edge as the classifier state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bc_sel   <= '0;
            bcm_sel  <= '0;
            orb_sel  <= '0;
            orbm_sel <= '0;
        end else begin
            bc_sel   <= bc_d;
            bcm_sel  <= bcm_d;
            orb_sel  <= orb_d;
            orbm_sel <= orbm_d;
        end
    end

    assign beam_active = (cls_q == CLS_BEAM);

endmodule

// File: rtl/mode_src_selector_chk.sv
module mode_src_selector_chk #(
    parameter int MODE_W  = 8,
    parameter int MASK_W  = 32,
    parameter int NUM_BC  = 3,
    parameter int NUM_ORB = 2,
    parameter int MBC_W   = 2,
    parameter int MORB_W  = 2,
    localparam int WM_W   = NUM_BC + NUM_ORB + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rx_ready,
    input logic [MODE_W-1:0]  mode_num,
    input logic [MASK_W-1:0]  beam_mask,
    input logic [WM_W-1:0]    working_mode,
    input logic [NUM_BC-1:0]  bc_man_sel,
    input logic [MBC_W-1:0]   bcm_man_sel,
    input logic [NUM_ORB-1:0] orb_beam_sel,
    input logic [NUM_ORB-1:0] orb_nobeam_sel,
    input logic [NUM_BC-1:0]  bc_sel,
    input logic [MBC_W-1:0]   bcm_sel,
    input logic [NUM_ORB-1:0] orb_sel,
    input logic [MORB_W-1:0]  orbm_sel,
    input logic               beam_active
);

    localparam int IDX_W   = (MASK_W > 1) ? $clog2(MASK_W) : 1;
    localparam int WM_BCM  = NUM_BC;
    localparam int WM_ORB0 = NUM_BC + 1;

    logic past_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    assert_beam_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(rx_ready) && ({1'b0, $past(mode_num)} < MASK_W)
        |-> beam_active == $past(beam_mask[mode_num[IDX_W-1:0]]));

    assert_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !$past(rx_ready) |-> !beam_active);

    assert_out_of_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && ({1'b0, $past(mode_num)} >= MASK_W) |-> !beam_active);

    assert_manual_bc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !$past(working_mode[0]) |-> bc_sel[0] == $past(bc_man_sel[0]));

    assert_auto_beam_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(working_mode[WM_ORB0]) && beam_active
        |-> orb_sel[0] == $past(orb_beam_sel[0]));

    assert_auto_nobeam_R6: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && $past(working_mode[WM_ORB0]) && !beam_active
        |-> orb_sel[0] == $past(orb_nobeam_sel[0]));

    assert_orbm_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        orbm_sel != 2'd3);

    assert_main_bc_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        past_valid && !$past(working_mode[WM_BCM]) |-> bcm_sel == $past(bcm_man_sel));

endmodule

bind mode_src_selector mode_src_selector_chk #(
    .MODE_W  (MODE_W),
    .MASK_W  (MASK_W),
    .NUM_BC  (NUM_BC),
    .NUM_ORB (NUM_ORB),
    .MBC_W   (MBC_W),
    .MORB_W  (MORB_W)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_ready       (rx_ready),
    .mode_num       (mode_num),
    .beam_mask      (beam_mask),
    .working_mode   (working_mode),
    .bc_man_sel     (bc_man_sel),
    .bcm_man_sel    (bcm_man_sel),
    .orb_beam_sel   (orb_beam_sel),
    .orb_nobeam_sel (orb_nobeam_sel),
    .bc_sel         (bc_sel),
    .bcm_sel        (bcm_sel),
    .orb_sel        (orb_sel),
    .orbm_sel       (orbm_sel),
    .beam_active    (beam_active)
);

// File: tb/test_mode_src_selector.sv
module test_mode_src_selector;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_ready = 1'b0;
    logic [7:0]  mode_num = '0;
    logic [31:0] beam_mask = '0;
    logic [6:0]  working_mode = '0;
    logic [2:0]  bc_man_sel = '0, bc_beam_sel = '0, bc_nobeam_sel = '0;
    logic [1:0]  bcm_man_sel = '0, bcm_beam_sel = '0, bcm_nobeam_sel = '0;
    logic [1:0]  orb_man_sel = '0, orb_beam_sel = '0, orb_nobeam_sel = '0;
    logic [1:0]  orbm_man_sel = '0, orbm_beam_sel = '0, orbm_nobeam_sel = '0;

    logic [2:0]  bc_sel;
    logic [1:0]  bcm_sel;
    logic [1:0]  orb_sel;
    logic [1:0]  orbm_sel;
    logic        beam_active;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [9:0] exp_q[$];
    string      tag_q[$];
    logic [9:0] last_exp = '0;

    mode_src_selector i_mode_src_selector (
        .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .mode_num(mode_num),
        .beam_mask(beam_mask), .working_mode(working_mode),
        .bc_man_sel(bc_man_sel), .bc_beam_sel(bc_beam_sel), .bc_nobeam_sel(bc_nobeam_sel),
        .bcm_man_sel(bcm_man_sel), .bcm_beam_sel(bcm_beam_sel), .bcm_nobeam_sel(bcm_nobeam_sel),
        .orb_man_sel(orb_man_sel), .orb_beam_sel(orb_beam_sel), .orb_nobeam_sel(orb_nobeam_sel),
        .orbm_man_sel(orbm_man_sel), .orbm_beam_sel(orbm_beam_sel), .orbm_nobeam_sel(orbm_nobeam_sel),
        .bc_sel(bc_sel), .bcm_sel(bcm_sel), .orb_sel(orb_sel), .orbm_sel(orbm_sel),
        .beam_active(beam_active)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] observed();
        return {beam_active, bc_sel, bcm_sel, orb_sel, orbm_sel};
    endfunction

    // reference model written from the requirements
    function automatic logic [9:0] model();
        logic       b;
        logic [2:0] e_bc;
        logic [1:0] e_bcm, e_orb, e_orbm;
        b = rx_ready && (mode_num < 8'd32) && beam_mask[mode_num[4:0]];
        for (int i = 0; i < 3; i++)
            e_bc[i] = !working_mode[i] ? bc_man_sel[i] : (b ? bc_beam_sel[i] : bc_nobeam_sel[i]);
        e_bcm = !working_mode[3] ? bcm_man_sel : (b ? bcm_beam_sel : bcm_nobeam_sel);
        for (int i = 0; i < 2; i++)
            e_orb[i] = !working_mode[4+i] ? orb_man_sel[i] : (b ? orb_beam_sel[i] : orb_nobeam_sel[i]);
        e_orbm = !working_mode[6] ? orbm_man_sel : (b ? orbm_beam_sel : orbm_nobeam_sel);
        if (e_orbm == 2'd3) e_orbm = 2'd2;
        return {b, e_bc, e_bcm, e_orb, e_orbm};
    endfunction

    task automatic check(string tag, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: inputs are already set at a negedge; push expectation
    task automatic push_expect(string tag);
        exp_q.push_back(model());
        tag_q.push_back(tag);
    endtask

    // monitor: compares one item per cycle after the capturing edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [9:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(t, observed(), e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state with nonzero manual codes
        bc_man_sel = 3'b111; bcm_man_sel = 2'd3; orb_man_sel = 2'b11; orbm_man_sel = 2'd2;
        rx_ready = 1; mode_num = 8'd3; beam_mask = 32'h8;
        repeat (3) @(negedge clk);
        check("R1", observed(), 10'b0);
        rst_n = 1'b1;

        // R5: manual everywhere, beam present
        @(negedge clk);
        working_mode = 7'h00;
        bc_man_sel = 3'b101; bc_beam_sel = 3'b010; bc_nobeam_sel = 3'b011;
        bcm_man_sel = 2'd1; bcm_beam_sel = 2'd2; bcm_nobeam_sel = 2'd3;
        orb_man_sel = 2'b10; orb_beam_sel = 2'b01; orb_nobeam_sel = 2'b11;
        orbm_man_sel = 2'd1; orbm_beam_sel = 2'd0; orbm_nobeam_sel = 2'd2;
        push_expect("R5 manual beam");
        @(negedge clk); beam_mask = 32'h0; push_expect("R5 manual nobeam");

        // R6: automatic, beam then no beam
        @(negedge clk); working_mode = 7'h7F; beam_mask = 32'h8; push_expect("R6 auto beam");
        @(negedge clk); mode_num = 8'd0; beam_mask = 32'hE; push_expect("R6 auto nobeam");
        @(negedge clk); mode_num = 8'd2; push_expect("R6 auto ramping beam");

        // R9: change inputs, outputs must hold within the cycle
        @(negedge clk);
        rx_ready = 0;
        #1;
        check("R9 hold", observed(), last_exp);
        push_expect("R3 not ready");
        @(negedge clk); beam_mask = 32'hFFFF_FFFF; mode_num = 8'd1; push_expect("R3 not ready full mask");

        // R4: range boundary
        @(negedge clk); rx_ready = 1; mode_num = 8'd40; push_expect("R4 mode 40");
        @(negedge clk); mode_num = 8'd32; push_expect("R4 mode 32");
        @(negedge clk); mode_num = 8'd31; beam_mask = 32'h8000_0000; push_expect("R4 mode 31 beam");
        @(negedge clk); mode_num = 8'd255; beam_mask = 32'hFFFF_FFFF; push_expect("R4 mode 255");

        // R2: walk the mask over every index
        for (int k = 0; k < 32; k++) begin
            @(negedge clk); beam_mask = 32'h1 << k; mode_num = 8'(k); push_expect("R2 hit");
            @(negedge clk); mode_num = 8'((k + 1) % 32); push_expect("R2 miss");
        end

        // R7: one automatic bit at a time, beam and no beam
        for (int b = 0; b < 7; b++) begin
            @(negedge clk); working_mode = 7'(1 << b); beam_mask = 32'h8; mode_num = 8'd3;
            push_expect("R7 single bit beam");
            @(negedge clk); mode_num = 8'd0; push_expect("R7 single bit nobeam");
        end

        // R8: main orbit code 3 folded, manual and automatic
        @(negedge clk); working_mode = 7'h00; orbm_man_sel = 2'd3; push_expect("R8 manual 3");
        @(negedge clk); working_mode = 7'h40; orbm_nobeam_sel = 2'd3; push_expect("R8 auto 3");
        @(negedge clk); orbm_nobeam_sel = 2'd1; push_expect("R8 orbit 2");

        // R10: all main bunch-clock codes pass through
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); working_mode = 7'h00; bcm_man_sel = 2'(c); push_expect("R10 main bc code");
        end

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule